// File: doc/BRIEF.md
# Posted Column Command Scheduler

This block turns a stream of row-open requests into command-bus traffic for a DDR2-class memory device. Each request names a bank and a direction. The block places an ACTIVATE for that bank on the command outputs, and in the very next cycle it places the matching READ or WRITE. The device holds the column command internally for the programmed additive latency (AL). The controller therefore need not wait out the row-to-column delay, and when requests go to different banks the command bus stays full with no idle slots.

The block works out when each burst occupies the data bus from AL, the CAS latency (CL) and the burst length. A read burst starts AL+CL cycles after its READ. A write burst starts one cycle sooner. The block raises a read-window or a write-window output for every cycle of each burst. Before it accepts a request, it compares the burst window that request would produce with every window already booked. A request that would collide waits with `reqReady` low until its window fits. AL (0 to 4), CL (3 to 6) and the burst length are configuration inputs and are expected to stay constant while commands are in flight.

Top module: `al_cmd_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cmdCode` is 0 (NOP), both window outputs are low and `reqReady` is high.
- R2: A request accepted at a clock edge (`reqValid` and `reqReady` high) puts `cmdCode` = 1 (ACTIVATE) with `cmdBank` equal to the request's bank in the cycle that begins at that edge. In the cycle after that, it puts `cmdCode` = 2 (READ) or 3 (WRITE, when `reqWrite` was 1) with the same bank.
- R3: The read window of a READ issued in cycle c is high from cycle c+AL+CL onward.
- R4: The write window of a WRITE issued in cycle c is high from cycle c+AL+CL-1 onward.
- R5: Each window stays high for exactly 2 cycles when `cfgBurst8` is 0 (burst of 4) and for exactly 4 cycles when `cfgBurst8` is 1 (burst of 8).
- R6: When the new windows do not collide with booked ones, requests are accepted every second cycle. The command bus then carries ACTIVATE, column, ACTIVATE, column with no NOP between them, and `reqReady` is low in the cycle that carries an ACTIVATE.
- R7: Two ACTIVATE commands are never closer than ACT_GAP cycles (default 2).
- R8: A request whose window would overlap any booked read or write window is held off with `reqReady` low. It is accepted at the first edge at which its window no longer overlaps.
- R9: The read window and the write window are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAl | input | AL_W | Additive latency, 0 to 4 |
| cfgCl | input | CL_W | CAS latency, 3 to 6 |
| cfgBurst8 | input | 1 | 1 selects burst of 8, 0 selects burst of 4 |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqBank | input | BANK_W | Target bank of the request |
| reqReady | output | 1 | Request is taken at this clock edge |
| cmdCode | output | 2 | 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE |
| cmdBank | output | BANK_W | Bank of the command on `cmdCode` |
| rdWindow | output | 1 | Read data is due on the data bus in this cycle |
| wrWindow | output | 1 | Write data must be driven in this cycle |

## Verification
Take a request accepted at edge a. Its ACTIVATE is due in cycle a and its column command in cycle a+1. A read burst then begins in cycle a+1+AL+CL and a write burst in cycle a+1+AL+CL-1, and either lasts 2 or 4 cycles. The bench numbers every clock edge and logs each output at the falling edge under that number. It also records the edge at which each request was accepted. Each expected cycle is computed from these formulas and checked against the log, including the cycle just before and just after each window. Stall cases are judged by the distance between acceptance edges, which follows from the booked windows.

// File: rtl/al_sched_pkg.sv
package al_sched_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic actFire;   // request accepted: issue ACTIVATE, latch request
    logic colFire;   // issue the latched column command, book its window
  } strobe_t;

endpackage

// File: rtl/al_sched_ctrl.sv
module al_sched_ctrl
  import al_sched_pkg::*;
#(
  parameter int ACT_GAP = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    winFree,
  output logic    reqReady,
  output strobe_t strobe
);

  localparam int GAP_W = $clog2(ACT_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(ACT_GAP - 1);

  logic             colPending;
  logic [GAP_W-1:0] gapCnt;

  assign reqReady       = !colPending && (gapCnt == '0) && winFree;
  assign strobe.actFire = reqValid && reqReady;
  assign strobe.colFire = colPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colPending <= 1'b0;
      gapCnt     <= '0;
    end else begin
      colPending <= strobe.actFire;
      if (strobe.actFire) begin
        gapCnt <= GAP_LOAD;
      end else if (gapCnt != '0) begin
        gapCnt <= gapCnt - 1'b1;
      end
    end
  end

  // the column slot after an ACTIVATE is never given to a new request
  AST_READY_LOW_ON_COL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.actFire |=> !reqReady); // R6

endmodule

// File: rtl/al_sched_dp.sv
module al_sched_dp
  import al_sched_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int AL_W   = 3,
  parameter int CL_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AL_W-1:0]   cfgAl,
  input  logic [CL_W-1:0]   cfgCl,
  input  logic              cfgBurst8,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  strobe_t           strobe,
  output logic              winFree,
  output logic [1:0]        cmdCode,
  output logic [BANK_W-1:0] cmdBank,
  output logic              rdWindow,
  output logic              wrWindow
);

  // timeline long enough for the largest latency plus a burst of 8
  localparam int TL_DEPTH = (1 << AL_W) + (1 << CL_W) + 4;
  localparam int LAT_W    = $clog2(TL_DEPTH) + 1;

  logic [LAT_W-1:0]    readLat, burstLen;
  logic [LAT_W-1:0]    reqLat, reqEnd, pendLat, pendEnd;
  logic [TL_DEPTH-1:0] reqMask, pendMask, rdTl, wrTl, occAhead;
  logic                pendWrite;
  cmd_e                cmdQ;

  assign readLat  = LAT_W'(cfgAl) + LAT_W'(cfgCl);
  assign burstLen = cfgBurst8 ? LAT_W'(4) : LAT_W'(2);
  assign reqLat   = reqWrite  ? readLat - 1'b1 : readLat;
  assign reqEnd   = reqLat + burstLen;
  assign pendLat  = pendWrite ? readLat - 1'b1 : readLat;
  assign pendEnd  = pendLat + burstLen;

  // bit p of a mask = data bus busy p cycles after the column cycle
  for (genvar i = 0; i < TL_DEPTH; i++) begin : g_mask
    assign reqMask[i]  = (LAT_W'(i) >= reqLat)  && (LAT_W'(i) < reqEnd);
    assign pendMask[i] = (LAT_W'(i) >= pendLat) && (LAT_W'(i) < pendEnd);
  end

  // booked occupancy as it will look at the future column cycle (two shifts on)
  assign occAhead = (rdTl | wrTl) >> 2;
  assign winFree  = ~|(reqMask & occAhead);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ      <= CMD_NOP;
      cmdBank   <= '0;
      pendWrite <= 1'b0;
      rdTl      <= '0;
      wrTl      <= '0;
    end else begin
      if (strobe.actFire) begin
        cmdQ      <= CMD_ACT;
        cmdBank   <= reqBank;
        pendWrite <= reqWrite;
      end else if (strobe.colFire) begin
        cmdQ <= pendWrite ? CMD_WR : CMD_RD;
      end else begin
        cmdQ <= CMD_NOP;
      end
      if (strobe.colFire && !pendWrite) begin
        rdTl <= (rdTl >> 1) | pendMask;
      end else begin
        rdTl <= rdTl >> 1;
      end
      if (strobe.colFire && pendWrite) begin
        wrTl <= (wrTl >> 1) | pendMask;
      end else begin
        wrTl <= wrTl >> 1;
      end
    end
  end

  assign cmdCode  = cmdQ;
  assign rdWindow = rdTl[0];
  assign wrWindow = wrTl[0];

  AST_COL_FOLLOWS_ACT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_ACT) |=> ((cmdQ == CMD_RD) || (cmdQ == CMD_WR)) && $stable(cmdBank)); // R2
  AST_COL_HAS_ACT: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdQ == CMD_RD) || (cmdQ == CMD_WR)) |-> ($past(cmdQ) == CMD_ACT)); // R2
  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_ACT) |=> (cmdQ != CMD_ACT)); // R7
  AST_WIN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rdWindow && wrWindow)); // R9
  AST_CFG_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAl <= AL_W'(4)) && (cfgCl >= CL_W'(3)) && (cfgCl <= CL_W'(6))); // R3

endmodule

// File: rtl/al_cmd_sched.sv
module al_cmd_sched
  import al_sched_pkg::*;
#(
  parameter int BANK_W  = 3,
  parameter int AL_W    = 3,
  parameter int CL_W    = 3,
  parameter int ACT_GAP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AL_W-1:0]   cfgAl,
  input  logic [CL_W-1:0]   cfgCl,
  input  logic              cfgBurst8,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  output logic              reqReady,
  output logic [1:0]        cmdCode,
  output logic [BANK_W-1:0] cmdBank,
  output logic              rdWindow,
  output logic              wrWindow
);

  strobe_t strobe;
  logic    winFree;

  al_sched_ctrl #(.ACT_GAP(ACT_GAP)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .winFree  (winFree),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  al_sched_dp #(.BANK_W(BANK_W), .AL_W(AL_W), .CL_W(CL_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgAl     (cfgAl),
    .cfgCl     (cfgCl),
    .cfgBurst8 (cfgBurst8),
    .reqWrite  (reqWrite),
    .reqBank   (reqBank),
    .strobe    (strobe),
    .winFree   (winFree),
    .cmdCode   (cmdCode),
    .cmdBank   (cmdBank),
    .rdWindow  (rdWindow),
    .wrWindow  (wrWindow)
  );

endmodule

// File: tb/test_al_cmd_sched.sv
module test_al_cmd_sched;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cfgAl = 3'd2;
  logic [2:0] cfgCl = 3'd3;
  logic       cfgBurst8 = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqWrite = 1'b0;
  logic [2:0] reqBank = 3'd0;
  logic       reqReady;
  logic [1:0] cmdCode;
  logic [2:0] cmdBank;
  logic       rdWindow, wrWindow;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  logic [1:0] logCmd [0:8191];
  logic [2:0] logBank [0:8191];
  logic       logRd [0:8191];
  logic       logWr [0:8191];

  al_cmd_sched i_al_cmd_sched (
    .clk(clk), .rstN(rstN), .cfgAl(cfgAl), .cfgCl(cfgCl), .cfgBurst8(cfgBurst8),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqBank(reqBank), .reqReady(reqReady),
    .cmdCode(cmdCode), .cmdBank(cmdBank), .rdWindow(rdWindow), .wrWindow(wrWindow)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    logCmd[cyc & 8191]  = cmdCode;
    logBank[cyc & 8191] = cmdBank;
    logRd[cyc & 8191]   = rdWindow;
    logWr[cyc & 8191]   = wrWindow;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // expects window bits [s, s+len-1] high and s-1, s+len low
  task automatic check_window(input bit isWr, input int s, input int len, input string req);
    for (int c = s - 1; c <= s + len; c++) begin
      int v = isWr ? int'(logWr[c]) : int'(logRd[c]);
      int e = (c >= s && c < s + len) ? 1 : 0;
      check(v == e, req, v, e);
    end
  endtask

  // called at a negedge; returns at a negedge with reqValid low
  task automatic send(input bit w, input int b, output int accEdge);
    reqValid = 1'b1;
    reqWrite = w;
    reqBank  = 3'(b);
    forever begin
      #1;
      if (reqReady) begin
        accEdge = cyc + 1;
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    check(cmdCode == 2'd0, "R1 cmd NOP", cmdCode, 0);
    check(!rdWindow && !wrWindow, "R1 windows low", {rdWindow, wrWindow}, 0);
    #1;
    check(reqReady == 1'b1, "R1 ready", reqReady, 1);
  endtask

  task automatic t_single();
    int a;
    cfgAl = 3'd2; cfgCl = 3'd3; cfgBurst8 = 1'b0;
    send(1'b0, 5, a);
    drain();
    check(logCmd[a] == 2'd1, "R2 ACT", logCmd[a], 1);
    check(logBank[a] == 3'd5, "R2 ACT bank", logBank[a], 5);
    check(logCmd[a+1] == 2'd2, "R2 READ next cycle", logCmd[a+1], 2);
    check(logBank[a+1] == 3'd5, "R2 READ bank", logBank[a+1], 5);
    check_window(1'b0, a + 1 + 5, 2, "R3 R5 read AL2 CL3 BL4");
    cfgBurst8 = 1'b1;
    send(1'b1, 2, a);
    drain();
    check(logCmd[a+1] == 2'd3, "R2 WRITE", logCmd[a+1], 3);
    check_window(1'b1, a + 1 + 4, 4, "R4 R5 write AL2 CL3 BL8");
  endtask

  task automatic t_extremes();
    int a;
    cfgAl = 3'd4; cfgCl = 3'd6; cfgBurst8 = 1'b0;
    send(1'b0, 1, a);
    drain();
    check_window(1'b0, a + 1 + 10, 2, "R3 read AL4 CL6");
    cfgAl = 3'd0; cfgCl = 3'd3;
    send(1'b1, 1, a);
    drain();
    check_window(1'b1, a + 1 + 2, 2, "R4 write AL0 CL3");
  endtask

  task automatic t_packed();
    int a [4];
    cfgAl = 3'd3; cfgCl = 3'd4; cfgBurst8 = 1'b0;
    for (int k = 0; k < 4; k++) send(1'b0, k, a[k]);
    drain();
    for (int k = 1; k < 4; k++)
      check(a[k] - a[k-1] == 2, "R6 R7 accept spacing", a[k] - a[k-1], 2);
    for (int c = a[0]; c <= a[3] + 1; c++)
      check(logCmd[c] == ((c - a[0]) % 2 == 0 ? 2'd1 : 2'd2), "R6 no NOP gap",
            logCmd[c], (c - a[0]) % 2 == 0 ? 1 : 2);
    for (int k = 0; k < 4; k++)
      check(logBank[a[k]+1] == 3'(k), "R2 bank order", logBank[a[k]+1], k);
    check_window(1'b0, a[0] + 8, 8, "R3 R6 contiguous read windows");
  endtask

  task automatic t_collide();
    int a1, a2;
    cfgAl = 3'd2; cfgCl = 3'd3; cfgBurst8 = 1'b1;
    send(1'b0, 0, a1);
    send(1'b0, 1, a2);
    drain();
    check(a2 - a1 == 4, "R8 BL8 read stall", a2 - a1, 4);
    check_window(1'b0, a1 + 6, 8, "R8 windows abut");
    cfgAl = 3'd0; cfgBurst8 = 1'b0;
    send(1'b0, 2, a1);
    send(1'b1, 3, a2);
    drain();
    check(a2 - a1 == 3, "R8 read then write stall", a2 - a1, 3);
    check_window(1'b1, a1 + 6, 2, "R4 R8 write after read");
    send(1'b1, 4, a1);
    send(1'b0, 5, a2);
    drain();
    check(a2 - a1 == 2, "R8 write then read no stall", a2 - a1, 2);
    for (int c = 0; c < cyc; c++)
      if (logRd[c] && logWr[c]) check(1'b0, "R9 windows overlap", c, -1);
    check(1'b1, "R9 scan", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_extremes();
    t_packed();
    t_collide();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule